// File: doc/BRIEF.md
# Burst Read Latency Sequencer

This block is the read side of a synchronous burst memory. The host first programs a 3-bit latency code that sets the number of initial access cycles. It then starts a read by pulling the active-low address-valid strobe low for one clock, with a start address and a burst mode. The block waits out the programmed latency and then returns one word per clock from an internal word array. It raises a ready flag that tells the host when data is about to arrive or is present.

Fixed bursts of 8, 16 or 32 words wrap inside their aligned window, so they never leave the aligned 64-word region that holds the start address. Continuous reads walk through the whole array. Each time they cross a 64-word boundary they stop for one cycle with ready low. A new address-valid strobe aborts any read in progress and starts a fresh one.

Top module: `burst_read_seq`

## Requirements
- R1: A legal latency code c (0 to 5) gives L = c + 2 total initial access cycles. The edge that samples adv_ni low counts as the first of these cycles. The first word shows on data_o with valid_o high after edge E0+L-1, where E0 is that sampling edge.
- R2: After reset the latency code is 5, so L is 7. A reset always restores this value, even if another code was written before.
- R3: A configuration write with code 6 or 7 is ignored, and the previous latency stays in effect.
- R4: For L of 3 or more, ready_o goes high one cycle before the first word. For L of 2, ready_o goes high in the same cycle as the first word. ready_o is high whenever valid_o is high.
- R5: mode_i selects the burst type: 0 gives 8 words, 1 gives 16 words, 2 gives 32 words and 3 gives a continuous read. A fixed burst delivers exactly that many words, one per cycle, and then valid_o and ready_o drop.
- R6: In a fixed burst of N words from start address S, word i comes from address (S with its low log2(N) bits cleared) plus ((S + i) mod N). The burst therefore stays inside the aligned 64-word region.
- R7: A continuous read delivers consecutive addresses, wrapping modulo the array size, until a new read starts.
- R8: In a continuous read, after the word at an address whose low 6 bits are all ones, one cycle follows with valid_o and ready_o low. The next address is then delivered.
- R9: adv_ni sampled low during a read aborts that read. After that edge valid_o and ready_o are low, and the new read follows the R1 timing from the new address.
- R10: mode_i and addr_i are sampled only at the edge where adv_ni is low. Later changes have no effect on the read in progress.
- R11: The array word at address a equals the low DW bits of (a * 40503) XOR 0xC3A5.
- R12: While reset is asserted, valid_o and ready_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Latency configuration write strobe |
| cfg_code_i | input | 3 | Latency code to be written |
| adv_ni | input | 1 | Active-low address-valid strobe that starts a read |
| addr_i | input | AW | Read start address |
| mode_i | input | 2 | Burst mode: 0 = 8 words, 1 = 16 words, 2 = 32 words, 3 = continuous |
| data_o | output | DW | Read data word |
| valid_o | output | 1 | data_o holds a word of the current read |
| ready_o | output | 1 | Ready flag, raised ahead of or with the data |

## Verification
The bench sweeps every legal latency code, including the 2-cycle case where ready must not lead the data. A design that counts from the wrong edge, or that always raises ready early, shifts the whole trace by one cycle.

Fixed bursts start at unaligned addresses, so a design that increments straight past its window instead of wrapping returns the wrong words. Continuous reads cross both a mid-array boundary and the top of the array. A missing stall, or a stall with ready left high, shows up as misplaced words.

Reserved codes, a reset after reprogramming, mode changes after the strobe, and aborts in both latency and data phases catch designs that latch stale settings or keep streaming after an abort.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    MODE_W8   = 2'd0,
    MODE_W16  = 2'd1,
    MODE_W32  = 2'd2,
    MODE_CONT = 2'd3
  } burst_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAT,
    ST_DATA,
    ST_STALL
  } seq_state_e;

  localparam int unsigned REGION_BITS  = 6;
  localparam int unsigned CODE_W       = 3;
  localparam int unsigned CYC_W        = 4;
  localparam int unsigned LEN_W        = 6;
  localparam logic [CODE_W-1:0] CODE_DEFAULT = 3'd5;
  localparam logic [CODE_W-1:0] CODE_MAX     = 3'd5;

  function automatic logic code_legal(input logic [CODE_W-1:0] c);
    return c <= CODE_MAX;
  endfunction

  function automatic logic [CYC_W-1:0] code_cycles(input logic [CODE_W-1:0] c);
    return {1'b0, c} + CYC_W'(2);
  endfunction

endpackage

// File: rtl/burst_lat_cfg.sv
module burst_lat_cfg
  import burst_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CYC_W-1:0]  cycles_o
);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      code_q <= CODE_DEFAULT;
    else if (we_i && code_legal(code_i)) code_q <= code_i;
  end

  assign code_o   = code_q;
  assign cycles_o = code_cycles(code_q);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  logic [1:0]    mode_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o,
  output burst_mode_e   mode_o,
  output logic          done_o,
  output logic          region_entry_o
);

  burst_mode_e      mode_q;
  logic [AW-1:0]    ptr_q;
  logic [LEN_W-1:0] left_q;
  logic [AW-1:0]    win_mask;
  logic [AW-1:0]    ptr_inc;
  logic [AW-1:0]    ptr_nxt;
  logic [LEN_W-1:0] load_len;

  always_comb begin
    unique case (burst_mode_e'(mode_i))
      MODE_W8:  load_len = LEN_W'(8);
      MODE_W16: load_len = LEN_W'(16);
      MODE_W32: load_len = LEN_W'(32);
      default:  load_len = '0;
    endcase
  end

  always_comb begin
    unique case (mode_q)
      MODE_W8:  win_mask = AW'(7);
      MODE_W16: win_mask = AW'(15);
      MODE_W32: win_mask = AW'(31);
      default:  win_mask = '1;
    endcase
  end

  assign ptr_inc = ptr_q + AW'(1);
  assign ptr_nxt = (ptr_q & ~win_mask) | (ptr_inc & win_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_W8;
      ptr_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      mode_q <= burst_mode_e'(mode_i);
      ptr_q  <= start_i;
      left_q <= load_len;
    end else if (step_i) begin
      ptr_q <= ptr_nxt;
      if (mode_q != MODE_CONT) left_q <= left_q - LEN_W'(1);
    end
  end

  assign ptr_o          = ptr_q;
  assign mode_o         = mode_q;
  assign done_o         = (mode_q != MODE_CONT) && (left_q == '0);
  assign region_entry_o = (mode_q == MODE_CONT) && (ptr_q[REGION_BITS-1:0] == '0);

endmodule

// File: rtl/burst_word_rom.sv
module burst_word_rom #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);

  localparam int unsigned DEPTH = 1 << AW;

  function automatic logic [DW-1:0] word_of(input int unsigned a);
    logic [31:0] p;
    p = (a * 32'd40503) ^ 32'h0000_C3A5;
    return DW'(p);
  endfunction

  logic [DW-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign rom[g] = word_of(g);
  end

  assign data_o = rom[addr_i];

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_code_i,
  input  logic          adv_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    mode_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          ready_o
);

  localparam int unsigned CNT_W = CYC_W - 1;

  logic [CODE_W-1:0] lat_code;
  logic [CYC_W-1:0]  lat_cycles;
  logic [AW-1:0]     ptr;
  logic [DW-1:0]     rom_word;
  burst_mode_e       burst_mode;
  logic              burst_done;
  logic              region_entry;
  logic              load;
  logic              step;

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DW-1:0]     data_q;
  logic              valid_q;
  logic              ready_q;

  assign load = !adv_ni;

  burst_lat_cfg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .code_i   (cfg_code_i),
    .code_o   (lat_code),
    .cycles_o (lat_cycles)
  );

  burst_addr_gen #(.AW(AW)) u_agen (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .load_i         (load),
    .start_i        (addr_i),
    .mode_i         (mode_i),
    .step_i         (step),
    .ptr_o          (ptr),
    .mode_o         (burst_mode),
    .done_o         (burst_done),
    .region_entry_o (region_entry)
  );

  burst_word_rom #(.AW(AW), .DW(DW)) u_rom (
    .addr_i (ptr),
    .data_o (rom_word)
  );

  // a word leaves the array on this edge
  always_comb begin
    unique case (state_q)
      ST_LAT:   step = (cnt_q == CNT_W'(1));
      ST_DATA:  step = !burst_done && !region_entry;
      ST_STALL: step = 1'b1;
      default:  step = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ready_q <= 1'b0;
    end else if (load) begin
      state_q <= ST_LAT;
      cnt_q   <= CNT_W'(lat_cycles - CYC_W'(1));
      valid_q <= 1'b0;
      ready_q <= 1'b0;
    end else if (step) begin
      state_q <= ST_DATA;
      data_q  <= rom_word;
      valid_q <= 1'b1;
      ready_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_LAT: begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(2)) ready_q <= 1'b1;
        end
        ST_DATA: begin
          state_q <= burst_done ? ST_IDLE : ST_STALL;
          valid_q <= 1'b0;
          ready_q <= 1'b0;
        end
        default: begin
          valid_q <= 1'b0;
          ready_q <= 1'b0;
        end
      endcase
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign ready_o = ready_q;

endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [2:0]    cfg_code_i,
  input logic          adv_ni,
  input logic          valid_o,
  input logic          ready_o,
  input seq_state_e    state_q,
  input logic [2:0]    lat_code,
  input logic [AW-1:0] ptr,
  input logic          step,
  input burst_mode_e   burst_mode
);

  assert_valid_has_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ready_o);

  assert_reserved_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_code_i > 3'd5) |=> $stable(lat_code));

  assert_abort_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_ni |=> (!valid_o && !ready_o));

  assert_stall_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STALL) |-> (!valid_o && !ready_o));

  assert_region_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && adv_ni && burst_mode != MODE_CONT)
      |=> (ptr[AW-1:REGION_BITS] == $past(ptr[AW-1:REGION_BITS])));

endmodule

bind burst_read_seq burst_read_seq_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_code_i (cfg_code_i),
  .adv_ni     (adv_ni),
  .valid_o    (valid_o),
  .ready_o    (ready_o),
  .state_q    (state_q),
  .lat_code   (lat_code),
  .ptr        (ptr),
  .step       (step),
  .burst_mode (burst_mode)
);

// File: tb/burst_read_seq_test.sv
module burst_read_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [2:0]    cfg_code_i = '0;
  logic          adv_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [1:0]    mode_i = '0;
  logic [DW-1:0] data_o;
  logic          valid_o;
  logic          ready_o;

  typedef struct {
    int          cyc;
    bit          v;
    bit          r;
    logic [15:0] d;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  int   model_code = 5;
  bit   done = 0;

  burst_read_seq #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_code_i(cfg_code_i),
    .adv_ni(adv_ni), .addr_i(addr_i), .mode_i(mode_i),
    .data_o(data_o), .valid_o(valid_o), .ready_o(ready_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // R11 array contents
  function automatic logic [15:0] word_of(int a);
    logic [31:0] p;
    p = (a * 32'd40503) ^ 32'h0000_C3A5;
    return p[15:0];
  endfunction

  task automatic check(bit ok, string tag, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: compare outputs with the scoreboard entry due this cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc == cyc) begin
      exp_t e;
      bit ok;
      e = sb.pop_front();
      ok = (valid_o == e.v) && (ready_o == e.r) && (!e.v || data_o == e.d);
      check(ok, e.tag,
            $sformatf("v=%0b r=%0b d=%h", valid_o, ready_o, data_o),
            $sformatf("v=%0b r=%0b d=%h", e.v, e.r, e.d));
    end
  end

  task automatic cfg_write(int code);
    cfg_we_i = 1'b1;
    cfg_code_i = 3'(code);
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (code <= 5) model_code = code;
  endtask

  task automatic do_reset();
    #1;
    rst_ni = 1'b0;
    #1;
    check(valid_o == 0 && ready_o == 0, "R12 reset state",
          $sformatf("v=%0b r=%0b", valid_o, ready_o), "v=0 r=0");
    @(negedge clk);
    rst_ni = 1'b1;
    model_code = 5; // R2 default
    @(negedge clk);
  endtask

  // driver: starts a read and pushes n expected cycles; called and returns at a negedge
  task automatic read(int addr, int mode, int n, string tag);
    int lat, len, ptr, emitted, base;
    bit stall;
    lat = model_code + 2;
    len = (mode == 0) ? 8 : (mode == 1) ? 16 : (mode == 2) ? 32 : 0;
    ptr = addr; emitted = 0; stall = 0;
    adv_ni = 1'b0;
    addr_i = AW'(addr);
    mode_i = 2'(mode);
    base = cyc + 1;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.cyc = base + k; e.d = '0;
      if (k < lat - 1) begin
        e.v = 0; e.r = (lat >= 3 && k == lat - 2);
        e.tag = {tag, " R1/R4 latency"};
      end else if (mode != 3 && emitted == len) begin
        e.v = 0; e.r = 0; e.tag = {tag, " R5 burst end"};
      end else if (stall) begin
        e.v = 0; e.r = 0; e.tag = {tag, " R8 stall"}; stall = 0;
      end else begin
        e.v = 1; e.r = 1; e.d = word_of(ptr);
        e.tag = {tag, " R6/R7/R11 data"};
        emitted++;
        if (mode == 3) begin
          if ((ptr & 63) == 63) stall = 1;
          ptr = (ptr + 1) & ((1 << AW) - 1);
        end else begin
          ptr = (ptr & ~(len - 1)) | ((ptr + 1) & (len - 1));
        end
      end
      sb.push_back(e);
    end
    @(negedge clk);
    adv_ni = 1'b1;
    mode_i = ~2'(mode); // R10: later changes must not matter
    addr_i = ~AW'(addr);
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    read('h10, 0, 6 + 8 + 2, "R2 default");
    cfg_write(0);
    read('h25, 1, 1 + 16 + 2, "R1 L2");
    cfg_write(3);
    read('h5C, 2, 4 + 32 + 2, "R1 L5");
    cfg_write(6);
    cfg_write(7);
    read('h07, 0, 4 + 8 + 2, "R3 reserved");
    cfg_write(1);
    read('h3C, 3, 2 + 20, "R7 cont");
    read('hFD, 3, 2 + 10, "R9 abort-cont");
    cfg_write(2);
    read('h40, 2, 10, "R9 abort-fixed");
    read('h80, 0, 2, "R9 abort-latency");
    read('h8B, 0, 3 + 8 + 2, "R10 mode hold");
    cfg_write(4);
    read('hAF, 1, 5 + 16 + 2, "R1 L6");
    cfg_write(0);
    do_reset();
    read('hF9, 0, 6 + 8 + 2, "R2 after reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule